// File: doc/BRIEF.md
# CPU Clock Prescaler with Standby Control

This block makes the CPU clock enable for a small microcontroller core. A 4-bit control register, written by the core through a simple write port at a fixed I/O address, holds two fields. The low field picks one of four divide ratios (64, 16, 8 or 4) applied to the main oscillator tick. The high field picks the power state: run, halt or stop. A separate system-clock select input bypasses the main path and derives the CPU clock from the subsystem oscillator tick divided by four.

Encodings that are not allowed are rejected field by field. A rejected field keeps its previous legal value and raises a sticky error flag. A wake-up input returns the power state to run. A change of ratio or source is applied only when the current CPU clock period completes, so the enable never arrives early or as a short pulse.

Top module: `cpu_clkgen`

## Requirements
- R1: Synchronous reset clears the control register to 0000 and the error flag to 0. After reset the CPU enable period is 64 main ticks.
- R2: A write with `wr_addr` equal to `CTRL_ADDR` (default 12'hFB3) loads `wr_data` into the register, subject to R5, R6 and R9. A write to any other address leaves `ctrl_q` unchanged.
- R3: With `sys_sel` = 0, bits [1:0] of 00, 01, 10 and 11 give one `cpu_en` pulse every 64, 16, 8 and 4 `main_tick` pulses.
- R4: With `sys_sel` = 1, `cpu_en` pulses once every 4 `sub_tick` pulses, whatever bits [1:0] hold.
- R5: While `fast_range` = 1, a written bits [1:0] value of 11 is rejected. The divide field keeps its old value and `cfg_err` is set.
- R6: A written bits [3:2] value of 11 is rejected. The mode field keeps its old value and `cfg_err` is set. `cfg_err` stays set until reset.
- R7: Mode 01 (halt) keeps `cpu_en` low while the divider keeps counting.
- R8: Mode 10 (stop) keeps `cpu_en` low and freezes the divider count.
- R9: `wake` forces bits [3:2] to 00 at the next clock edge, even against a write in the same cycle. The next `cpu_en` comes when the divider next completes a period.
- R10: A new ratio or source takes effect only after the current period completes under the old setting.
- R11: `cpu_en` is a one-cycle pulse. It is raised in the clock cycle after the tick that completes a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the core |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 4 | Write data: [3:2] mode, [1:0] divide |
| main_tick | input | 1 | Main oscillator clock enable |
| sub_tick | input | 1 | Subsystem oscillator clock enable |
| sys_sel | input | 1 | 1 selects the subsystem source |
| fast_range | input | 1 | Strap: main oscillator is in the upper frequency range |
| wake | input | 1 | Wake-up request |
| cpu_en | output | 1 | CPU clock enable pulse |
| ctrl_q | output | 4 | Current control register value |
| cfg_err | output | 1 | Sticky flag for a rejected setting |

## Verification
The bench sweeps every divide code against several main tick spacings and checks the pulse gap arithmetically. A wrong ratio or a tick that is not gated would show up as a wrong gap. It changes the ratio from 64 to 4 in the middle of a period; a design that switches at once would produce a gap shorter than 64. It parks the divider in stop mode and checks the exact delay to the first pulse after wake. A design that kept counting in stop, or that restarted the count, would give a different delay. It also writes rejected codes in both ranges and a halt write at the same time as wake; mistakes there show up as a corrupted `ctrl_q` or a missing or lost error flag.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int CNT_W   = 6;
    localparam int SUB_DIV = 4;

    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_HALT = 2'b01,
        PM_STOP = 2'b10,
        PM_BAD  = 2'b11
    } pmode_t;

    typedef enum logic [1:0] {
        DV_64 = 2'b00,
        DV_16 = 2'b01,
        DV_8  = 2'b10,
        DV_4  = 2'b11
    } dsel_t;

    typedef struct packed {
        pmode_t mode;
        dsel_t  dsel;
    } ctrl_t;

    typedef struct packed {
        logic  sub;
        dsel_t dsel;
    } clkcfg_t;

    // Terminal count (period minus one) for an applied configuration.
    function automatic logic [CNT_W-1:0] period_m1(clkcfg_t c);
        logic [CNT_W-1:0] r;
        if (c.sub) begin
            r = CNT_W'(SUB_DIV - 1);
        end else begin
            case (c.dsel)
                DV_64:   r = CNT_W'(63);
                DV_16:   r = CNT_W'(15);
                DV_8:    r = CNT_W'(7);
                default: r = CNT_W'(3);
            endcase
        end
        return r;
    endfunction

    function automatic logic div_illegal(logic [1:0] code, logic fast);
        return fast && (code == 2'b11);
    endfunction

    function automatic logic mode_illegal(logic [1:0] code);
        return code == 2'b11;
    endfunction

endpackage

// File: rtl/cg_ctrl_reg.sv
module cg_ctrl_reg
    import clkgen_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'hFB3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_data,
    input  logic              fast_range,
    input  logic              wake,
    output ctrl_t             ctrl,
    output logic              err
);

    logic  hit;
    logic  bad;
    ctrl_t nxt;

    assign hit = wr_en && (wr_addr == CTRL_ADDR);

    always_comb begin
        nxt = ctrl;
        bad = 1'b0;
        if (hit) begin
            if (mode_illegal(wr_data[3:2])) begin
                bad = 1'b1;
            end else begin
                nxt.mode = pmode_t'(wr_data[3:2]);
            end
            if (div_illegal(wr_data[1:0], fast_range)) begin
                bad = 1'b1;
            end else begin
                nxt.dsel = dsel_t'(wr_data[1:0]);
            end
        end
        if (wake) begin
            nxt.mode = PM_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '{mode: PM_RUN, dsel: DV_64};
            err  <= 1'b0;
        end else begin
            ctrl <= nxt;
            if (bad) begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cg_divider.sv
module cg_divider
    import clkgen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  main_tick,
    input  logic  sub_tick,
    input  logic  sys_sel,
    input  ctrl_t ctrl,
    output logic  cpu_en
);

    clkcfg_t          cur;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             run;
    logic             last;
    logic             bnd;

    assign tick = cur.sub ? sub_tick : main_tick;
    assign run  = (ctrl.mode != PM_STOP);
    assign last = (cnt == period_m1(cur));
    assign bnd  = run && tick && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '{sub: 1'b0, dsel: DV_64};
            cnt    <= '0;
            cpu_en <= 1'b0;
        end else begin
            cpu_en <= bnd && (ctrl.mode == PM_RUN);
            if (run && tick) begin
                if (last) begin
                    cnt <= '0;
                    cur <= '{sub: sys_sel, dsel: ctrl.dsel};
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cpu_clkgen.sv
module cpu_clkgen
    import clkgen_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'hFB3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_data,
    input  logic              main_tick,
    input  logic              sub_tick,
    input  logic              sys_sel,
    input  logic              fast_range,
    input  logic              wake,
    output logic              cpu_en,
    output logic [3:0]        ctrl_q,
    output logic              cfg_err
);

    ctrl_t ctrl;

    cg_ctrl_reg #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .fast_range (fast_range),
        .wake       (wake),
        .ctrl       (ctrl),
        .err        (cfg_err)
    );

    cg_divider u_div (
        .clk       (clk),
        .rst       (rst),
        .main_tick (main_tick),
        .sub_tick  (sub_tick),
        .sys_sel   (sys_sel),
        .ctrl      (ctrl),
        .cpu_en    (cpu_en)
    );

    assign ctrl_q = ctrl;

endmodule

// File: rtl/cg_chk.sv
module cg_chk #(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'hFB3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wake,
    input logic              cpu_en,
    input logic [3:0]        ctrl_q,
    input logic              cfg_err
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ctrl_q == 4'b0000) && !cfg_err);

    // R2
    foreign_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr != CTRL_ADDR) && !wake) |=> $stable(ctrl_q));

    // R6
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[3:2] != 2'b11);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    // R7
    run_only_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_en) |-> ($past(ctrl_q[3:2]) == 2'b00));

    // R9
    wake_run_chk: assert property (@(posedge clk) disable iff (rst)
        wake |=> (ctrl_q[3:2] == 2'b00));

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_en |=> !cpu_en);

endmodule

bind cpu_clkgen cg_chk #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
) i_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wake    (wake),
    .cpu_en  (cpu_en),
    .ctrl_q  (ctrl_q),
    .cfg_err (cfg_err)
);

// File: tb/test_cpu_clkgen.sv
module test_cpu_clkgen;

    localparam int          ADDR_W = 12;
    localparam logic [11:0] CADDR  = 12'hFB3;
    localparam int          LIMIT  = 3000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [3:0]        wr_data = '0;
    logic              main_tick = 1'b0;
    logic              sub_tick = 1'b0;
    logic              sys_sel = 1'b0;
    logic              fast_range = 1'b0;
    logic              wake = 1'b0;
    logic              cpu_en;
    logic [3:0]        ctrl_q;
    logic              cfg_err;

    int mspace = 1;
    int sspace = 5;
    int mph = 0;
    int sph = 0;
    int nchk = 0;
    int nbad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    cpu_clkgen #(.ADDR_W(ADDR_W), .CTRL_ADDR(CADDR)) i_cpu_clkgen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .main_tick(main_tick), .sub_tick(sub_tick), .sys_sel(sys_sel),
        .fast_range(fast_range), .wake(wake), .cpu_en(cpu_en),
        .ctrl_q(ctrl_q), .cfg_err(cfg_err)
    );

    always @(negedge clk) begin
        mph = (mph >= mspace - 1) ? 0 : mph + 1;
        sph = (sph >= sspace - 1) ? 0 : sph + 1;
        main_tick = (mph == 0);
        sub_tick  = (sph == 0);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nbad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [3:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic next_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_en && n < LIMIT);
    endtask

    task automatic count_pulses(input int win, output int p);
        p = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (cpu_en) p++;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    int g, p, expv;

    initial begin
        do_reset();
        // R1: reset state and default period
        check(ctrl_q == 4'b0000, "R1 ctrl", ctrl_q, 0);
        check(cfg_err == 1'b0, "R1 err", cfg_err, 0);
        next_pulse(g); next_pulse(g);
        check(g == 64, "R1 period", g, 64);

        // R3: sweep every code against several tick spacings
        for (int s = 1; s <= 3; s++) begin
            mspace = s;
            for (int d = 0; d < 4; d++) begin
                wr(CADDR, 4'(d));
                next_pulse(g); next_pulse(g); next_pulse(g);
                expv = ((d == 0) ? 64 : (32 >> d)) * s;
                check(g == expv, "R3 gap", g, expv);
            end
        end
        mspace = 1;

        // R10: change 64 -> 4 in mid period
        wr(CADDR, 4'b0000);
        next_pulse(g); next_pulse(g);
        repeat (9) @(negedge clk);
        wr(CADDR, 4'b0011);
        next_pulse(g);
        check(g + 10 == 64, "R10 old period kept", g + 10, 64);
        next_pulse(g);
        check(g == 4, "R10 new period", g, 4);

        // R4: subsystem source, divide field ignored
        sys_sel = 1'b1;
        sspace = 5;
        next_pulse(g); next_pulse(g); next_pulse(g);
        check(g == 20, "R4 sub gap", g, 20);
        wr(CADDR, 4'b0000);
        next_pulse(g); next_pulse(g); next_pulse(g);
        check(g == 20, "R4 field ignored", g, 20);
        sys_sel = 1'b0;
        next_pulse(g); next_pulse(g); next_pulse(g);
        check(g == 64, "R4 back to main", g, 64);

        // R2: foreign address ignored
        wr(CADDR + 12'd1, 4'b0110);
        check(ctrl_q == 4'b0000, "R2 foreign addr", ctrl_q, 0);
        wr(CADDR, 4'b0001);
        check(ctrl_q == 4'b0001, "R2 load", ctrl_q, 1);

        // R5: fast range rejects code 11
        fast_range = 1'b1;
        wr(CADDR, 4'b0010);
        check(ctrl_q == 4'b0010 && !cfg_err, "R5 legal in fast", {cfg_err, ctrl_q}, 2);
        wr(CADDR, 4'b0011);
        check(ctrl_q == 4'b0010, "R5 field kept", ctrl_q, 2);
        check(cfg_err == 1'b1, "R5 err", cfg_err, 1);

        // R6: mode 11 rejected, divide field still loads, err sticky
        wr(CADDR, 4'b1101);
        check(ctrl_q == 4'b0001, "R6 mode kept", ctrl_q, 1);
        wr(CADDR, 4'b0000);
        check(cfg_err == 1'b1, "R6 sticky", cfg_err, 1);
        do_reset();
        check(cfg_err == 1'b0, "R6 cleared by reset", cfg_err, 0);
        wr(CADDR, 4'b1100);
        check(cfg_err == 1'b1 && ctrl_q == 4'b0000, "R6 mode-only reject", {cfg_err, ctrl_q}, 16);
        do_reset();
        fast_range = 1'b0;
        wr(CADDR, 4'b0011);
        check(ctrl_q == 4'b0011 && !cfg_err, "R5 code 11 legal in slow", {cfg_err, ctrl_q}, 3);

        // R7: halt suppresses pulses, wake resumes within one period
        next_pulse(g); next_pulse(g);
        wr(CADDR, 4'b0111);
        count_pulses(50, p);
        check(p == 0, "R7 halt pulses", p, 0);
        wake = 1'b1; @(negedge clk); wake = 1'b0;
        check(ctrl_q == 4'b0011, "R9 wake to run", ctrl_q, 3);
        next_pulse(g);
        check(g >= 1 && g <= 5, "R7 divider ran in halt", g, 4);

        // R8: stop freezes the count; exact delay after wake
        wr(CADDR, 4'b0001);
        next_pulse(g); next_pulse(g);
        wr(CADDR, 4'b1001);
        count_pulses(100, p);
        check(p == 0, "R8 stop pulses", p, 0);
        wake = 1'b1; @(negedge clk); wake = 1'b0;
        next_pulse(g);
        check(g == 15, "R8 frozen count", g, 15);
        next_pulse(g);
        check(g == 16, "R9 period after wake", g, 16);

        // R9: wake beats a same-cycle halt write
        wr_en = 1'b1; wr_addr = CADDR; wr_data = 4'b0110; wake = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wake = 1'b0;
        check(ctrl_q == 4'b0010, "R9 wake priority", ctrl_q, 2);

        // R11: single-cycle pulse at fastest rate
        wr(CADDR, 4'b0011);
        next_pulse(g); next_pulse(g);
        @(negedge clk);
        check(cpu_en == 1'b0, "R11 pulse width", cpu_en, 0);
        next_pulse(g);
        check(g == 3, "R11 gap after width check", g, 3);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

endmodule